// File: doc/BRIEF.md
# Sample Delay Calibrator

This block chooses the receive-sampling delay tap for a serial read path. When started, it walks through the candidate taps in ascending order. For each tap it presents the tap on its output, so the delay line outside the block samples with that setting, and issues one read of a fixed test register over a request/response port. Taps whose reply equals the known pattern 0x5AA5 are marked in a pass mask.

After the last tap, the block looks at the mask. When the passing taps form one unbroken run, it selects the centre of that run and keeps it on the tap output. When the mask is empty or has a gap, it raises an error flag instead. A one-cycle done pulse marks the end of the sequence. The serial link and the delay line are outside the block.

The request channel and the response channel both use valid/ready. The request stays valid, with a stable address, until the far side accepts it. That side may hold off acceptance for as long as it needs: no timeout runs while a request waits. The response side is ready only while a reply is awaited, and any data presented at other times is not taken.

Top module: `sample_delay_cal`

## Requirements
- R1: A start pulse while idle begins a sweep that visits taps 0, 1, 2, 3 in that order; during each step `tap_o` shows the tap under test.
- R2: Each step issues exactly one read request to address `TEST_ADDR` (default 0x00A0). `req_valid_o` stays high and `req_addr_o` stays stable until a cycle with `req_ready_i` high.
- R3: A response accepted for tap i sets bit i of `pass_mask_o` exactly when its data equals 0x5AA5. Any other value leaves the bit clear.
- R4: After a request is accepted, `resp_ready_o` stays high for at most `TIMEOUT` cycles. If no response arrives in that window, the tap counts as failed and the sweep moves on.
- R5: A response that arrives in the last cycle of the window is taken and judged by its data; it is not counted as a timeout.
- R6: If the final mask is non-zero and its set bits are contiguous from lo to hi, `err_o` is 0 and `tap_o` is floor((lo+hi)/2).
- R7: If the final mask is zero or its set bits are not contiguous, `err_o` is 1 and `tap_o` is 0.
- R8: `done_o` is high for exactly one cycle, and in that cycle `tap_o`, `pass_mask_o` and `err_o` already carry the results. All three hold until the next start.
- R9: A start pulse while a sweep is running is ignored.
- R10: After reset, `tap_o`, `pass_mask_o`, `done_o`, `err_o`, `busy_o`, `req_valid_o` and `resp_ready_o` are all 0.
- R11: Only one read is outstanding at a time: `req_valid_o` and `resp_ready_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a calibration sweep (ignored while busy) |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Read request accepted |
| req_addr_o | output | 16 | Address of the test register |
| resp_valid_i | input | 1 | Read response valid |
| resp_ready_o | output | 1 | Block is waiting for a response |
| resp_data_i | input | 16 | Read response data |
| tap_o | output | 2 | Tap under test during the sweep, chosen tap afterwards |
| pass_mask_o | output | 4 | Bit i set when tap i returned the pattern |
| done_o | output | 1 | One-cycle end-of-sweep pulse |
| err_o | output | 1 | No usable contiguous window |
| busy_o | output | 1 | Sweep in progress |

## Verification
The response and the timeout can fall in the same cycle. This happens when a reply arrives in the last cycle of the wait window, and the reply must win. The bench provokes the case by delaying every reply by exactly `TIMEOUT`-1 cycles after acceptance. It then judges the outcome at the ports: the resulting pass mask and chosen tap must match what the reply data dictate, as if no timeout existed.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_PICK,
    ST_DONE
  } sdc_state_e;
endpackage

// File: rtl/sdc_timer.sv
module sdc_timer #(
  parameter int LIMIT = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (en_i && !last_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sdc_window.sv
module sdc_window #(
  parameter int NUM_TAPS = 4,
  localparam int TAP_W = (NUM_TAPS < 2) ? 1 : $clog2(NUM_TAPS)
) (
  input  logic [NUM_TAPS-1:0] mask_i,
  output logic                usable_o,
  output logic [TAP_W-1:0]    centre_o
);
  logic [TAP_W-1:0]    lo, hi;
  logic [NUM_TAPS-1:0] aligned, bumped;
  logic [TAP_W:0]      span_sum;

  always_comb begin
    lo = '0;
    hi = '0;
    for (int i = NUM_TAPS - 1; i >= 0; i--) begin
      if (mask_i[i]) lo = TAP_W'(i);
    end
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (mask_i[i]) hi = TAP_W'(i);
    end
    aligned  = mask_i >> lo;
    bumped   = aligned + 1'b1;
    usable_o = (|mask_i) && ((aligned & bumped) == '0);
    span_sum = {1'b0, lo} + {1'b0, hi};
    centre_o = span_sum[TAP_W:1];
  end
endmodule

// File: rtl/sdc_seq.sv
module sdc_seq
  import sdc_pkg::*;
#(
  parameter int          NUM_TAPS = 4,
  parameter int          DATA_W   = 16,
  parameter logic [DATA_W-1:0] EXPECT = 16'h5AA5,
  localparam int TAP_W = (NUM_TAPS < 2) ? 1 : $clog2(NUM_TAPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                req_ready_i,
  input  logic                resp_valid_i,
  input  logic [DATA_W-1:0]   resp_data_i,
  input  logic                tmo_last_i,
  input  logic                usable_i,
  input  logic [TAP_W-1:0]    centre_i,
  output logic                tmo_clr_o,
  output logic                tmo_en_o,
  output logic                req_valid_o,
  output logic                resp_ready_o,
  output logic [TAP_W-1:0]    tap_o,
  output logic [NUM_TAPS-1:0] mask_o,
  output logic                done_o,
  output logic                err_o,
  output logic                busy_o
);
  sdc_state_e          state_q;
  logic [TAP_W-1:0]    idx_q;
  logic [TAP_W-1:0]    tap_q;
  logic [NUM_TAPS-1:0] mask_q;
  logic                err_q;
  logic                last_step;
  logic                step_end;

  assign last_step = (idx_q == TAP_W'(NUM_TAPS - 1));
  assign step_end  = (state_q == ST_WAIT) && (resp_valid_i || tmo_last_i);

  assign req_valid_o  = (state_q == ST_REQ);
  assign resp_ready_o = (state_q == ST_WAIT);
  assign tmo_clr_o    = (state_q != ST_WAIT);
  assign tmo_en_o     = (state_q == ST_WAIT) && !resp_valid_i;
  assign done_o       = (state_q == ST_DONE);
  assign busy_o       = (state_q != ST_IDLE);
  assign tap_o        = tap_q;
  assign mask_o       = mask_q;
  assign err_o        = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      tap_q   <= '0;
      mask_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            idx_q   <= '0;
            tap_q   <= '0;
            mask_q  <= '0;
            err_q   <= 1'b0;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (req_ready_i) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          // a reply in the final window cycle is judged, not timed out
          if (resp_valid_i) mask_q[idx_q] <= (resp_data_i == EXPECT);
          if (step_end) begin
            if (last_step) begin
              state_q <= ST_PICK;
            end else begin
              idx_q   <= idx_q + 1'b1;
              tap_q   <= idx_q + 1'b1;
              state_q <= ST_REQ;
            end
          end
        end
        ST_PICK: begin
          tap_q   <= usable_i ? centre_i : '0;
          err_q   <= !usable_i;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sample_delay_cal.sv
module sample_delay_cal #(
  parameter int                NUM_TAPS  = 4,
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] TEST_ADDR = 16'h00A0,
  parameter logic [DATA_W-1:0] EXPECT    = 16'h5AA5,
  parameter int                TIMEOUT   = 255,
  localparam int TAP_W = (NUM_TAPS < 2) ? 1 : $clog2(NUM_TAPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  output logic                req_valid_o,
  input  logic                req_ready_i,
  output logic [ADDR_W-1:0]   req_addr_o,
  input  logic                resp_valid_i,
  output logic                resp_ready_o,
  input  logic [DATA_W-1:0]   resp_data_i,
  output logic [TAP_W-1:0]    tap_o,
  output logic [NUM_TAPS-1:0] pass_mask_o,
  output logic                done_o,
  output logic                err_o,
  output logic                busy_o
);
  logic             tmo_clr, tmo_en, tmo_last;
  logic             usable;
  logic [TAP_W-1:0] centre;

  assign req_addr_o = TEST_ADDR;

  sdc_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (tmo_clr),
    .en_i   (tmo_en),
    .last_o (tmo_last)
  );

  sdc_window #(.NUM_TAPS(NUM_TAPS)) u_window (
    .mask_i   (pass_mask_o),
    .usable_o (usable),
    .centre_o (centre)
  );

  sdc_seq #(
    .NUM_TAPS (NUM_TAPS),
    .DATA_W   (DATA_W),
    .EXPECT   (EXPECT)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .req_ready_i  (req_ready_i),
    .resp_valid_i (resp_valid_i),
    .resp_data_i  (resp_data_i),
    .tmo_last_i   (tmo_last),
    .usable_i     (usable),
    .centre_i     (centre),
    .tmo_clr_o    (tmo_clr),
    .tmo_en_o     (tmo_en),
    .req_valid_o  (req_valid_o),
    .resp_ready_o (resp_ready_o),
    .tap_o        (tap_o),
    .mask_o       (pass_mask_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .busy_o       (busy_o)
  );
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
  parameter int NUM_TAPS = 4,
  parameter int ADDR_W   = 16,
  parameter int TIMEOUT  = 255,
  localparam int TAP_W = (NUM_TAPS < 2) ? 1 : $clog2(NUM_TAPS),
  localparam int CW    = $clog2(TIMEOUT + 2) + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                req_valid_o,
  input logic                req_ready_i,
  input logic [ADDR_W-1:0]   req_addr_o,
  input logic                resp_ready_o,
  input logic [TAP_W-1:0]    tap_o,
  input logic [NUM_TAPS-1:0] pass_mask_o,
  input logic                done_o,
  input logic                err_o,
  input logic                busy_o
);
  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wait_cnt <= '0;
    else if (!resp_ready_o) wait_cnt <= '0;
    else if (wait_cnt != '1) wait_cnt <= wait_cnt + 1'b1;
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o));

  p_wait_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_ready_o |-> wait_cnt < CW'(TIMEOUT));

  p_pick_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !err_o |-> pass_mask_o[tap_o]);

  p_err_tap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && err_o |-> tap_o == '0);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i |=> $stable(tap_o) && $stable(pass_mask_o) && $stable(err_o));

  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid_o && resp_ready_o));
endmodule

bind sample_delay_cal sdc_checker #(
  .NUM_TAPS (NUM_TAPS),
  .ADDR_W   (ADDR_W),
  .TIMEOUT  (TIMEOUT)
) u_sdc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .req_valid_o  (req_valid_o),
  .req_ready_i  (req_ready_i),
  .req_addr_o   (req_addr_o),
  .resp_ready_o (resp_ready_o),
  .tap_o        (tap_o),
  .pass_mask_o  (pass_mask_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .busy_o       (busy_o)
);

// File: tb/test_sample_delay_cal.sv
module test_sample_delay_cal;
  localparam int          T    = 6;
  localparam logic [15:0] ADDR = 16'h00A0;
  localparam logic [15:0] PAT  = 16'h5AA5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        req_valid_o, req_ready_i = 1'b0;
  logic [15:0] req_addr_o;
  logic        resp_valid_i = 1'b0, resp_ready_o;
  logic [15:0] resp_data_i = '0;
  logic [1:0]  tap_o;
  logic [3:0]  pass_mask_o;
  logic        done_o, err_o, busy_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  sample_delay_cal #(.TIMEOUT(T)) i_sample_delay_cal (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
    .resp_valid_i(resp_valid_i), .resp_ready_o(resp_ready_o), .resp_data_i(resp_data_i),
    .tap_o(tap_o), .pass_mask_o(pass_mask_o), .done_o(done_o), .err_o(err_o),
    .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // expected result computed by counting ones against span width
  task automatic expect_of(input logic [3:0] m, output bit e_err, output int e_tap);
    int lo = -1, hi = -1, ones = 0;
    for (int i = 0; i < 4; i++) begin
      if (m[i]) begin
        if (lo < 0) lo = i;
        hi = i;
        ones++;
      end
    end
    if (ones == 0 || ones != hi - lo + 1) begin
      e_err = 1'b1;
      e_tap = 0;
    end else begin
      e_err = 1'b0;
      e_tap = (lo + hi) / 2;
    end
  endtask

  task automatic serve(input int i, input bit good, input bit tmo, input int rdy_dly, input int rsp_dly);
    int cnt = 0;
    while (!req_valid_o) @(negedge clk);
    chk(tap_o == 2'(i), "R1 tap under test", int'(tap_o), i);
    chk(req_addr_o == ADDR, "R2 address", int'(req_addr_o), int'(ADDR));
    chk(!resp_ready_o, "R11 one outstanding", int'(resp_ready_o), 0);
    for (int k = 0; k < rdy_dly; k++) begin
      @(negedge clk);
      chk(req_valid_o && req_addr_o == ADDR, "R2 held under back-pressure", int'(req_valid_o), 1);
    end
    req_ready_i = 1'b1;
    @(negedge clk);
    req_ready_i = 1'b0;
    if (tmo) begin
      while (resp_ready_o && cnt < 100) begin
        cnt++;
        @(negedge clk);
      end
      chk(cnt == T, "R4 wait window length", cnt, T);
    end else begin
      for (int k = 0; k < rsp_dly; k++) @(negedge clk);
      chk(resp_ready_o, "R5 ready in window", int'(resp_ready_o), 1);
      resp_valid_i = 1'b1;
      resp_data_i  = good ? PAT : (PAT ^ (16'h1 << (i * 4 + 1)));
      @(negedge clk);
      resp_valid_i = 1'b0;
      resp_data_i  = '0;
    end
  endtask

  task automatic finish_check(input logic [3:0] m, input string tag);
    bit e_err;
    int e_tap;
    int cnt = 0;
    expect_of(m, e_err, e_tap);
    while (!done_o && cnt < 10) begin
      cnt++;
      @(negedge clk);
    end
    chk(done_o, "R8 done seen", int'(done_o), 1);
    chk(pass_mask_o == m, {"R3 mask ", tag}, int'(pass_mask_o), int'(m));
    chk(err_o == e_err, e_err ? "R7 error flag" : "R6 error flag", int'(err_o), int'(e_err));
    chk(int'(tap_o) == e_tap, e_err ? "R7 tap" : "R6 chosen tap", int'(tap_o), e_tap);
    @(negedge clk);
    chk(!done_o, "R8 done one cycle", int'(done_o), 0);
    repeat (3) @(negedge clk);
    chk(int'(tap_o) == e_tap && pass_mask_o == m && err_o == e_err, "R8 results held",
        int'(tap_o), e_tap);
  endtask

  task automatic run_cal(input logic [3:0] m, input bit tmo_mode, input int rdy_dly, input int rsp_dly);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 4; i++) serve(i, m[i], tmo_mode && !m[i], rdy_dly, rsp_dly);
    finish_check(m, tmo_mode ? "timeout" : "data");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(tap_o == 0 && pass_mask_o == 0, "R10 reset outputs", int'({tap_o, pass_mask_o}), 0);
    chk(!done_o && !err_o && !busy_o, "R10 reset flags", int'({done_o, err_o, busy_o}), 0);
    chk(!req_valid_o && !resp_ready_o, "R10 reset handshake", int'({req_valid_o, resp_ready_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int m = 0; m < 16; m++) begin
      for (int mode = 0; mode < 2; mode++) begin
        run_cal(4'(m), mode[0], m % 3, (mode == 0) ? (m % 4) : 0);
      end
    end

    // R5: reply lands in the last cycle of the window
    run_cal(4'hF, 1'b0, 0, T - 1);
    run_cal(4'b0110, 1'b0, 1, T - 1);
    run_cal(4'b0100, 1'b0, 0, T - 1);

    // R9: start during a sweep is ignored
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    serve(0, 1'b0, 1'b0, 0, 1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(tap_o == 2'd1, "R9 start ignored while busy", int'(tap_o), 1);
    serve(1, 1'b1, 1'b0, 0, 0);
    serve(2, 1'b1, 1'b0, 0, 0);
    serve(3, 1'b0, 1'b1, 0, 0);
    finish_check(4'b0110, "after ignored start");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired R1 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule